// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the pins of a serial flash slave and its command sequencer. It runs on a fast system clock that oversamples the serial clock, chip select and pause pins through synchronizers. It turns serial-clock edges into one-cycle strobes for the downstream shift logic and samples the serial input on each rising strobe.

When the active-low pause pin is asserted while the device is selected, the transfer freezes. The rising and falling strobes are suppressed, so bit counters and shift registers keep their values, and the serial output enable is forced off. Entry into pause and exit from it only take effect while the synchronized serial clock is low. A pause-pin edge that arrives while the clock is high waits for the next low phase.

Deselecting the device ends any pause at once and holds the sequencer in reset. A single registered `hold_active_o` flag reports the pause state.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `hold_active_o`, `sck_rise_o`, `sck_fall_o`, `so_oe_o` and `si_bit_o` are 0 and `seq_rst_o` is 1. The synchronizers reset to the idle pin levels: SCK low, CS_N high, HOLD_N high.
- R2: While the synchronized CS_N is high, `hold_active_o` stays 0 whatever HOLD_N does.
- R3: If HOLD_N falls while CS_N is low and SCK is low, `hold_active_o` becomes 1 at the third rising system-clock edge after the pin change (two synchronizer stages plus the state register).
- R4: If HOLD_N falls while SCK is high, pause does not start until SCK goes low. It then starts three system-clock edges after the SCK fall. `hold_active_o` changes only on a cycle in which the synchronized SCK was low, except when it is cleared by deselect.
- R5: A HOLD_N rise follows the same rule as entry: it takes effect three edges later if SCK is low, and otherwise is deferred until SCK goes low.
- R6: While paused, no `sck_rise_o` or `sck_fall_o` strobe is produced.
- R7: While paused or deselected, `so_oe_o` is 0. Otherwise it follows `so_oe_i`, and `so_o` carries `so_data_i` while it is enabled and is 0 otherwise.
- R8: Driving CS_N high clears the pause three system-clock edges later and asserts `seq_rst_o` for as long as the synchronized CS_N is high.
- R9: With CS_N low and no pause, each SCK rising edge gives exactly one one-cycle `sck_rise_o` pulse three system-clock edges after the pin change. `si_bit_o` takes the SI level present with that edge in the same cycle. Each SCK falling edge gives one `sck_fall_o` pulse with the same latency. The two strobes are never high together.
- R10: The pause persists for as long as HOLD_N stays low and CS_N stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| cs_ni | input | 1 | Chip select pin, active low |
| hold_ni | input | 1 | Pause pin, active low |
| si_i | input | 1 | Serial data input pin |
| so_data_i | input | 1 | Output bit from the sequencer |
| so_oe_i | input | 1 | Sequencer request to drive the output |
| sck_rise_o | output | 1 | Masked rising-edge strobe |
| sck_fall_o | output | 1 | Masked falling-edge strobe |
| si_bit_o | output | 1 | SI level captured at the last rising strobe |
| so_o | output | 1 | Output data toward the pad |
| so_oe_o | output | 1 | Output pad enable; 0 means high impedance |
| seq_rst_o | output | 1 | Sequencer reset while deselected |
| hold_active_o | output | 1 | Pause state flag |

## Verification
The bench goes after pause-pin edges that land while SCK is high. A design that applied them at once would raise or drop `hold_active_o` in the middle of a clock-high phase, and a strobe would be lost or duplicated.

It keeps HOLD_N low for long stretches and toggles SCK inside the pause. This catches a design that leaks strobes, which would corrupt the frozen bit count, or that enables the output during the pause.

It also deselects the device during a pause with HOLD_N still low. A design that failed to clear the flag, or that re-entered the pause while deselected, would leave the next transfer frozen.

Random pin activity is compared cycle by cycle against a bench model built from the latency rules.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  parameter int unsigned SYNC_STAGES = 2;
  parameter int unsigned PIN_CNT     = 4;
  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_CS   = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned PIN_SI   = 3;
  // idle levels: sck low, cs_n high, hold_n high, si low
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 4'b0110;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  assign rise_o = sck_s_i & ~sck_q;
  assign fall_o = ~sck_s_i & sck_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic cs_n_s_i,
  input  logic hold_n_s_i,
  output logic hold_q_o,
  output logic hold_d_o
);
  // state may only move in an sck-low phase; deselect clears it at once
  always_comb begin
    hold_d_o = hold_q_o;
    if (cs_n_s_i)     hold_d_o = 1'b0;
    else if (!sck_s_i) hold_d_o = ~hold_n_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q_o <= 1'b0;
    else         hold_q_o <= hold_d_o;
  end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic hold_ni,
  input  logic si_i,
  input  logic so_data_i,
  input  logic so_oe_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_bit_o,
  output logic so_o,
  output logic so_oe_o,
  output logic seq_rst_o,
  output logic hold_active_o
);
  logic [PIN_CNT-1:0] pin_raw, pin_s;
  logic sck_s, cs_n_s, hold_n_s, si_s;
  logic rise_raw, fall_raw;
  logic hold_q, hold_d;

  always_comb begin
    pin_raw           = '0;
    pin_raw[PIN_SCK]  = sck_i;
    pin_raw[PIN_CS]   = cs_ni;
    pin_raw[PIN_HOLD] = hold_ni;
    pin_raw[PIN_SI]   = si_i;
  end

  spi_hold_sync #(
    .WIDTH  (PIN_CNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  assign sck_s    = pin_s[PIN_SCK];
  assign cs_n_s   = pin_s[PIN_CS];
  assign hold_n_s = pin_s[PIN_HOLD];
  assign si_s     = pin_s[PIN_SI];

  spi_hold_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(sck_s),
    .rise_o (rise_raw),
    .fall_o (fall_raw)
  );

  spi_hold_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (sck_s),
    .cs_n_s_i  (cs_n_s),
    .hold_n_s_i(hold_n_s),
    .hold_q_o  (hold_q),
    .hold_d_o  (hold_d)
  );

  // a rise can only follow a low phase, so the current state already applies;
  // a fall may coincide with entry, so mask it with the next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_rise_o <= 1'b0;
      sck_fall_o <= 1'b0;
      si_bit_o   <= 1'b0;
      seq_rst_o  <= 1'b1;
    end else begin
      sck_rise_o <= rise_raw & ~cs_n_s & ~hold_q;
      sck_fall_o <= fall_raw & ~cs_n_s & ~hold_d;
      seq_rst_o  <= cs_n_s;
      if (rise_raw & ~cs_n_s & ~hold_q) si_bit_o <= si_s;
    end
  end

  assign hold_active_o = hold_q;
  assign so_oe_o       = so_oe_i & ~hold_q & ~cs_n_s;
  assign so_o          = so_oe_o & so_data_i;
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_s,
  input logic cs_n_s,
  input logic sck_rise_o,
  input logic sck_fall_o,
  input logic so_oe_o,
  input logic seq_rst_o,
  input logic hold_active_o
);
  AST_NO_HOLD_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_n_s) |-> !hold_active_o); // R2

  AST_MOVE_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_active_o != $past(hold_active_o)) && !seq_rst_o |-> !$past(sck_s)); // R4

  AST_NO_RISE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_active_o) |-> !sck_rise_o); // R6

  AST_NO_FALL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_active_o |-> !sck_fall_o); // R6

  AST_SO_OFF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_active_o |-> !so_oe_o); // R7

  AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rst_o |-> !hold_active_o); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_rise_o && sck_fall_o)); // R9
endmodule

bind spi_hold_ctrl spi_hold_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sck_s        (sck_s),
  .cs_n_s       (cs_n_s),
  .sck_rise_o   (sck_rise_o),
  .sck_fall_o   (sck_fall_o),
  .so_oe_o      (so_oe_o),
  .seq_rst_o    (seq_rst_o),
  .hold_active_o(hold_active_o)
);

// File: tb/spi_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_hold_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic so_data = 1'b0, so_oe = 1'b0;
  logic rise_o, fall_o, si_bit_o, so_o, so_oe_o, seq_rst_o, hold_o;
  int total = 0, bad = 0, cyc = 0;
  int rise_cnt = 0, fall_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_hold_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .hold_ni(hold_n),
    .si_i(si), .so_data_i(so_data), .so_oe_i(so_oe),
    .sck_rise_o(rise_o), .sck_fall_o(fall_o), .si_bit_o(si_bit_o),
    .so_o(so_o), .so_oe_o(so_oe_o), .seq_rst_o(seq_rst_o), .hold_active_o(hold_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  // bench model built from the latency rules: two sync stages, then the state register
  logic m1_sck = 0, m1_cs = 1, m1_hold = 1, m1_si = 0;
  logic m2_sck = 0, m2_cs = 1, m2_hold = 1, m2_si = 0;
  logic m_sckq = 0, m_hold = 0, m_rise = 0, m_fall = 0, m_si = 0, m_rst = 1;

  function automatic logic next_hold(input logic cs_s, input logic sck_s,
                                     input logic hn_s, input logic cur);
    if (cs_s) return 1'b0;
    if (!sck_s) return ~hn_s;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_sck <= 0; m1_cs <= 1; m1_hold <= 1; m1_si <= 0;
      m2_sck <= 0; m2_cs <= 1; m2_hold <= 1; m2_si <= 0;
      m_sckq <= 0; m_hold <= 0; m_rise <= 0; m_fall <= 0; m_si <= 0; m_rst <= 1;
    end else begin
      logic hd, rr;
      hd = next_hold(m2_cs, m2_sck, m2_hold, m_hold);
      rr = m2_sck & ~m_sckq & ~m2_cs & ~m_hold;
      m1_sck <= sck; m1_cs <= cs_n; m1_hold <= hold_n; m1_si <= si;
      m2_sck <= m1_sck; m2_cs <= m1_cs; m2_hold <= m1_hold; m2_si <= m1_si;
      m_sckq <= m2_sck;
      m_hold <= hd;
      m_rise <= rr;
      m_fall <= ~m2_sck & m_sckq & ~m2_cs & ~hd;
      m_rst  <= m2_cs;
      if (rr) m_si <= m2_si;
    end
  end

  // compare a quarter period after each edge, inputs move on the falling edge
  always @(posedge clk) begin
    cyc++;
    #5;
    if (rst_n && !done) begin
      check("R3/R4/R5 hold_active_o", hold_o, m_hold);
      check("R6/R9 sck_rise_o", rise_o, m_rise);
      check("R6/R9 sck_fall_o", fall_o, m_fall);
      check("R9 si_bit_o", si_bit_o, m_si);
      check("R8 seq_rst_o", seq_rst_o, m_rst);
      check("R7 so_oe_o", so_oe_o, so_oe & ~m_hold & ~m2_cs);
      check("R7 so_o", so_o, so_oe & ~m_hold & ~m2_cs & so_data);
      if (rise_o) rise_cnt++;
      if (fall_o) fall_cnt++;
    end
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    step(2);
    // r1_ reset values
    check("R1 hold_active_o", hold_o, 1'b0);
    check("R1 sck_rise_o", rise_o, 1'b0);
    check("R1 sck_fall_o", fall_o, 1'b0);
    check("R1 so_oe_o", so_oe_o, 1'b0);
    check("R1 si_bit_o", si_bit_o, 1'b0);
    check("R1 seq_rst_o", seq_rst_o, 1'b1);
    rst_n = 1'b1;
    step(2);

    // R2: pause pin low while deselected
    hold_n = 0; step(6);
    check("R2 no hold when deselected", hold_o, 1'b0);
    hold_n = 1; cs_n = 0; so_oe = 1; so_data = 1; step(4);
    check("R7 output enabled when active", so_oe_o, 1'b1);

    // R9: strobe count and SI sampling
    rise_cnt = 0; fall_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      si = i[0]; sck = 1; step(4); sck = 0; step(4);
    end
    check("R9 rise strobe count", rise_cnt == 4, 1'b1);
    check("R9 fall strobe count", fall_cnt == 4, 1'b1);
    si = 1; sck = 1; step(2);
    check("R9 rise not yet", rise_o, 1'b0);
    step(1);
    check("R9 rise after three edges", rise_o, 1'b1);
    check("R9 si captured", si_bit_o, 1'b1);
    sck = 0; step(4);

    // R3: entry with sck low
    hold_n = 0; step(2);
    check("R3 not yet held", hold_o, 1'b0);
    step(1);
    check("R3 held after three edges", hold_o, 1'b1);
    check("R7 output off when held", so_oe_o, 1'b0);

    // R6: sck activity inside the pause
    rise_cnt = 0; fall_cnt = 0;
    for (int i = 0; i < 3; i++) begin sck = 1; step(4); sck = 0; step(4); end
    check("R6 no rise strobes held", rise_cnt == 0, 1'b1);
    check("R6 no fall strobes held", fall_cnt == 0, 1'b1);

    // R10: stays held
    step(40);
    check("R10 pause persists", hold_o, 1'b1);

    // R5: exit while sck high is deferred
    sck = 1; step(4); hold_n = 1; step(8);
    check("R5 exit deferred while sck high", hold_o, 1'b1);
    sck = 0; step(2);
    check("R5 not yet released", hold_o, 1'b1);
    step(1);
    check("R5 released after sck low", hold_o, 1'b0);

    // R4: entry while sck high is deferred
    sck = 1; step(4); hold_n = 0; step(8);
    check("R4 entry deferred while sck high", hold_o, 1'b0);
    sck = 0; step(2);
    check("R4 not yet held", hold_o, 1'b0);
    step(1);
    check("R4 held after sck low", hold_o, 1'b1);

    // R8: deselect during pause
    cs_n = 1; step(2);
    check("R8 still held before sync", hold_o, 1'b1);
    step(1);
    check("R8 cleared by deselect", hold_o, 1'b0);
    check("R8 sequencer reset", seq_rst_o, 1'b1);
    step(6);
    check("R2 stays clear while deselected", hold_o, 1'b0);
    hold_n = 1; cs_n = 0; step(4);
    check("R8 reset released", seq_rst_o, 1'b0);

    // random pin activity against the model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 0) sck = ~sck;
      if (r[6:3] == 0) hold_n = ~hold_n;
      if (r[12:7] == 0) cs_n = ~cs_n;
      si = r[13]; so_data = r[14];
      if (r[18:15] == 0) so_oe = ~so_oe;
      step(1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule